// File: doc/BRIEF.md
# Split Descriptor Ring Controller

This block owns a small descriptor store that holds both the transmit ring and the receive ring of an Ethernet-style MAC. There are 128 descriptors of two 32-bit words each. Word 0 carries a 16-bit length in bits [31:16] and flags in bits [15:0]. Word 1 carries a buffer pointer. A programmable split index divides the store. Descriptors below the split form the transmit ring, and descriptors from the split upward form the receive ring.

A host reads and writes the store through a simple word port. Enable inputs and a split-write port control the two rings. When a transmit descriptor is owned by hardware, the block announces a transmit with its length and pointer. It then hands the descriptor back with its status cleared. Frame-completion events from the receive datapath carry a length and a filter-miss flag. The block writes these into the current receive descriptor, or flags a busy condition when the host has not supplied an empty one. Each ring keeps its own index, and wrap flags in each descriptor can shorten a ring. Three sticky interrupt-source bits report these events.

Top module: `desc_ring_ctrl`

## Requirements
- R1: The host port uses a 10-bit byte address. The word index is address bits [9:2], so descriptor n has word 0 at byte 8n and word 1 at byte 8n+4. Read data appears on `host_rdata` one cycle after the request. After reset, every descriptor word is zero, the split is 64, the transmit index is 0, the receive index is 64 and `irq_src` is zero.
- R2: A split write with a value of 128 or more leaves the split unchanged. A smaller value is taken. The split never changes without a split write.
- R3: A receive event is taken only when `rx_enable` is high and was also high on the previous cycle (`rx_ready`). Otherwise the event changes no descriptor, no index and no interrupt bit.
- R4: A transmit check runs after every host write to the store, and after a rising edge of `tx_enable`. A transmit starts only if four things hold: `tx_enable` is high, the split is nonzero, the current transmit descriptor has bit 15 (ready) set, and its length exceeds 4. The start is reported by a one-cycle `tx_fire` together with `tx_len` and `tx_ptr`.
- R5: After a transmit, the transmit index becomes 0 if bit 13 (wrap) of the descriptor is set. Otherwise it increments, and it becomes 0 when it reaches the split.
- R6: After a transmit, bits 15, 8 and 7:0 of word 0 are cleared, and the length and bits 14:9 are kept. If bit 14 is set, `irq_src` bit 0 is set.
- R7: A taken receive event aimed at a descriptor whose bit 15 (empty) is clear sets `irq_src` bit 4. The descriptor and the receive index stay unchanged.
- R8: A taken receive event aimed at an empty descriptor does the following to word 0: it writes the event length into bits [31:16], clears bits 15 and 8:0, and sets bit 7 if the miss flag was set. Bits 14:9 are kept. If bit 14 is set, `irq_src` bit 2 is set.
- R9: After a receive write, the receive index returns to the split if the descriptor's bit 13 is set or the index is 127. Otherwise it increments.
- R10: A rising edge of `rx_enable` reloads the receive index with the split. A rising edge of `tx_enable` reloads the transmit index with 0.
- R11: Interrupt-source bits stay set until cleared by a 1 on the matching `irq_clr` bit. A new event wins over a clear in the same cycle.
- R12: When a host write and a ring status write hit the same word in one cycle, the ring value is stored. The ring value is computed from the word's previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the request |
| split_we | input | 1 | Split register write strobe |
| split_wdata | input | 8 | New split value |
| ring_split | output | 8 | Current split index |
| tx_enable | input | 1 | Transmit ring enable |
| rx_enable | input | 1 | Receive ring enable |
| rx_ev_valid | input | 1 | Received-frame completion event |
| rx_ev_len | input | 16 | Length of the received frame |
| rx_ev_miss | input | 1 | Address filter missed for this frame |
| rx_ready | output | 1 | Receive events are currently taken |
| tx_fire | output | 1 | One-cycle transmit start pulse |
| tx_len | output | 16 | Length of the started transmit |
| tx_ptr | output | 32 | Buffer pointer of the started transmit |
| tx_index | output | 7 | Current transmit descriptor index |
| rx_index | output | 7 | Current receive descriptor index |
| irq_clr | input | 5 | Write-one-to-clear for interrupt-source bits |
| irq_src | output | 5 | Interrupt sources: bit 0 tx done, bit 2 rx done, bit 4 busy |

## Verification
The bound checker watches five kinds of behaviour on every cycle:
- the split stays in range and never moves without a write;
- every transmit start is backed by an enable and a nonzero split;
- the transmit index after a start is either 0 or one step on, and always below the split;
- both index reloads happen on enable edges, and the receive index holds while receive is disabled;
- interrupt bits never drop without a clear.

Other behaviour depends on descriptor contents and needs the bench's scenarios to show it:
- exact status-word rewrites, and the preservation of bits 14:9;
- the length-above-4 rule;
- descriptor wrap flags versus the split and the 127 limit;
- the busy drop leaving the descriptor intact;
- the ring winning a same-cycle write collision with the host.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W = 16;
    localparam int IRQ_W = 5;

    // word 0 flag positions, shared by both rings
    localparam int BIT_OWN = 15;
    localparam int BIT_IRQ = 14;
    localparam int BIT_WRAP = 13;
    localparam int BIT_MISS = 7;

    // status rewrite keeps only bits 14:9 of the flag half
    localparam logic [15:0] KEEP_MASK = 16'h7E00;

    localparam int MIN_TX_LEN = 4;

    localparam int IRQ_TXDONE = 0;
    localparam int IRQ_RXDONE = 2;
    localparam int IRQ_BUSY = 4;
endpackage

// File: rtl/desc_store.sv
module desc_store
    import desc_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    localparam int IDX_W = $clog2(NUM_DESC),
    localparam int WI_W = IDX_W + 1,
    localparam int NUM_WORDS = 2 * NUM_DESC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_en,
    input  logic              h_we,
    input  logic [WI_W-1:0]   h_word,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_rdata,
    input  logic              r_we,
    input  logic [WI_W-1:0]   r_word,
    input  logic [WORD_W-1:0] r_wdata,
    input  logic [IDX_W-1:0]  tx_idx,
    input  logic [IDX_W-1:0]  rx_idx,
    output logic [WORD_W-1:0] tx_flags,
    output logic [WORD_W-1:0] tx_ptr,
    output logic [WORD_W-1:0] rx_flags
);
    logic [WORD_W-1:0] mem_q [NUM_WORDS];

    assign tx_flags = mem_q[{tx_idx, 1'b0}];
    assign tx_ptr   = mem_q[{tx_idx, 1'b1}];
    assign rx_flags = mem_q[{rx_idx, 1'b0}];

    // ring write is issued after the host write so it wins on a shared word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem_q[i] <= '0;
            end
            h_rdata <= '0;
        end else begin
            if (h_en && h_we) begin
                mem_q[h_word] <= h_wdata;
            end
            if (r_we) begin
                mem_q[r_word] <= r_wdata;
            end
            if (h_en && !h_we) begin
                h_rdata <= mem_q[h_word];
            end
        end
    end
endmodule

// File: rtl/desc_tx_ring.sv
module desc_tx_ring
    import desc_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    localparam int IDX_W = $clog2(NUM_DESC),
    localparam int SPLIT_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_enable,
    input  logic [SPLIT_W-1:0] split,
    input  logic               host_desc_wr,
    input  logic               grant,
    input  logic [WORD_W-1:0]  cur_flags,
    input  logic [WORD_W-1:0]  cur_ptr,
    output logic [IDX_W-1:0]   idx,
    output logic               wr_req,
    output logic [WORD_W-1:0]  wr_data,
    output logic               irq_set,
    output logic               fire,
    output logic [LEN_W-1:0]   len,
    output logic [WORD_W-1:0]  ptr
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              chk;
        logic              en_prev;
        logic              fire;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] ptr;
    } tx_state_t;

    tx_state_t s_q, s_d;
    logic               rise;
    logic               ready;
    logic               go;
    logic [LEN_W-1:0]   cur_len;
    logic [SPLIT_W-1:0] step;

    always_comb begin
        cur_len = cur_flags[WORD_W-1:WORD_W-LEN_W];
        rise    = tx_enable && !s_q.en_prev;
        ready   = tx_enable && (split != '0) && cur_flags[BIT_OWN]
                  && (cur_len > LEN_W'(MIN_TX_LEN));
        go      = !rise && s_q.chk && grant && ready;
        step    = {1'b0, s_q.idx} + SPLIT_W'(1);

        s_d         = s_q;
        s_d.en_prev = tx_enable;
        s_d.fire    = 1'b0;
        if (rise) begin
            s_d.idx = '0;
            s_d.chk = 1'b1;
        end else if (s_q.chk && grant) begin
            s_d.chk = 1'b0;
            if (ready) begin
                s_d.fire = 1'b1;
                s_d.len  = cur_len;
                s_d.ptr  = cur_ptr;
                if (cur_flags[BIT_WRAP] || step >= split) begin
                    s_d.idx = '0;
                end else begin
                    s_d.idx = step[IDX_W-1:0];
                end
            end
        end
        if (host_desc_wr) begin
            s_d.chk = 1'b1;
        end

        wr_req  = go;
        wr_data = {cur_len, cur_flags[15:0] & KEEP_MASK};
        irq_set = go && cur_flags[BIT_IRQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx  = s_q.idx;
    assign fire = s_q.fire;
    assign len  = s_q.len;
    assign ptr  = s_q.ptr;
endmodule

// File: rtl/desc_rx_ring.sv
module desc_rx_ring
    import desc_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    localparam int IDX_W = $clog2(NUM_DESC),
    localparam int SPLIT_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_enable,
    input  logic [SPLIT_W-1:0] split,
    input  logic               ev_valid,
    input  logic [LEN_W-1:0]   ev_len,
    input  logic               ev_miss,
    input  logic [WORD_W-1:0]  cur_flags,
    output logic [IDX_W-1:0]   idx,
    output logic               rx_ok,
    output logic               wr_req,
    output logic [WORD_W-1:0]  wr_data,
    output logic               busy_set,
    output logic               done_set
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             en_prev;
    } rx_state_t;

    rx_state_t s_q, s_d;
    logic        rise;
    logic        accept;
    logic [15:0] new_low;

    always_comb begin
        rise     = rx_enable && !s_q.en_prev;
        rx_ok    = rx_enable && s_q.en_prev && (split < SPLIT_W'(NUM_DESC));
        accept   = ev_valid && rx_ok;
        wr_req   = accept && cur_flags[BIT_OWN];
        busy_set = accept && !cur_flags[BIT_OWN];
        done_set = wr_req && cur_flags[BIT_IRQ];
        new_low  = cur_flags[15:0] & KEEP_MASK;
        new_low[BIT_MISS] = ev_miss;
        wr_data  = {ev_len, new_low};

        s_d         = s_q;
        s_d.en_prev = rx_enable;
        if (rise) begin
            s_d.idx = split[IDX_W-1:0];
        end else if (wr_req) begin
            if (cur_flags[BIT_WRAP] || s_q.idx == IDX_W'(NUM_DESC - 1)) begin
                s_d.idx = split[IDX_W-1:0];
            end else begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.idx <= IDX_W'(NUM_DESC / 2);
        end else begin
            s_q <= s_d;
        end
    end

    assign idx = s_q.idx;
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
    import desc_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    localparam int IDX_W = $clog2(NUM_DESC),
    localparam int SPLIT_W = IDX_W + 1,
    localparam int WI_W = IDX_W + 1,
    localparam int ADDR_W = WI_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_en,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    input  logic               split_we,
    input  logic [SPLIT_W-1:0] split_wdata,
    output logic [SPLIT_W-1:0] ring_split,
    input  logic               tx_enable,
    input  logic               rx_enable,
    input  logic               rx_ev_valid,
    input  logic [LEN_W-1:0]   rx_ev_len,
    input  logic               rx_ev_miss,
    output logic               rx_ready,
    output logic               tx_fire,
    output logic [LEN_W-1:0]   tx_len,
    output logic [WORD_W-1:0]  tx_ptr,
    output logic [IDX_W-1:0]   tx_index,
    output logic [IDX_W-1:0]   rx_index,
    input  logic [IRQ_W-1:0]   irq_clr,
    output logic [IRQ_W-1:0]   irq_src
);
    typedef struct packed {
        logic [SPLIT_W-1:0] split;
        logic [IRQ_W-1:0]   irq;
    } top_state_t;

    top_state_t s_q, s_d;

    logic [WORD_W-1:0] tx_flags, tx_word1, rx_flags;
    logic              tx_wr, rx_wr;
    logic [WORD_W-1:0] tx_wdata, rx_wdata;
    logic              tx_irq, rx_done, rx_busy;
    logic              r_we;
    logic [WI_W-1:0]   r_word;
    logic [WORD_W-1:0] r_wdata;
    logic              host_wr;

    assign host_wr = host_en && host_we;

    desc_store #(.NUM_DESC(NUM_DESC)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_en     (host_en),
        .h_we     (host_we),
        .h_word   (host_addr[ADDR_W-1:2]),
        .h_wdata  (host_wdata),
        .h_rdata  (host_rdata),
        .r_we     (r_we),
        .r_word   (r_word),
        .r_wdata  (r_wdata),
        .tx_idx   (tx_index),
        .rx_idx   (rx_index),
        .tx_flags (tx_flags),
        .tx_ptr   (tx_word1),
        .rx_flags (rx_flags)
    );

    desc_tx_ring #(.NUM_DESC(NUM_DESC)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_enable    (tx_enable),
        .split        (s_q.split),
        .host_desc_wr (host_wr),
        .grant        (!rx_wr),
        .cur_flags    (tx_flags),
        .cur_ptr      (tx_word1),
        .idx          (tx_index),
        .wr_req       (tx_wr),
        .wr_data      (tx_wdata),
        .irq_set      (tx_irq),
        .fire         (tx_fire),
        .len          (tx_len),
        .ptr          (tx_ptr)
    );

    desc_rx_ring #(.NUM_DESC(NUM_DESC)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_enable (rx_enable),
        .split     (s_q.split),
        .ev_valid  (rx_ev_valid),
        .ev_len    (rx_ev_len),
        .ev_miss   (rx_ev_miss),
        .cur_flags (rx_flags),
        .idx       (rx_index),
        .rx_ok     (rx_ready),
        .wr_req    (rx_wr),
        .wr_data   (rx_wdata),
        .busy_set  (rx_busy),
        .done_set  (rx_done)
    );

    always_comb begin
        // single ring write port: receive owns it when active, transmit waits
        r_we    = rx_wr || tx_wr;
        r_word  = rx_wr ? {rx_index, 1'b0} : {tx_index, 1'b0};
        r_wdata = rx_wr ? rx_wdata : tx_wdata;

        s_d = s_q;
        if (split_we && split_wdata < SPLIT_W'(NUM_DESC)) begin
            s_d.split = split_wdata;
        end
        s_d.irq = s_q.irq & ~irq_clr;
        s_d.irq[IRQ_TXDONE] = s_d.irq[IRQ_TXDONE] | tx_irq;
        s_d.irq[IRQ_RXDONE] = s_d.irq[IRQ_RXDONE] | rx_done;
        s_d.irq[IRQ_BUSY]   = s_d.irq[IRQ_BUSY] | rx_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.split <= SPLIT_W'(NUM_DESC / 2);
            s_q.irq   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ring_split = s_q.split;
    assign irq_src    = s_q.irq;
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk
    import desc_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    localparam int IDX_W = $clog2(NUM_DESC),
    localparam int SPLIT_W = IDX_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               split_we,
    input logic [SPLIT_W-1:0] ring_split,
    input logic               tx_enable,
    input logic               rx_enable,
    input logic               tx_fire,
    input logic [IDX_W-1:0]   tx_index,
    input logic [IDX_W-1:0]   rx_index,
    input logic [IRQ_W-1:0]   irq_clr,
    input logic [IRQ_W-1:0]   irq_src
);
    AST_SPLIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ring_split < SPLIT_W'(NUM_DESC)); // R2
    AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !split_we |=> $stable(ring_split)); // R2
    AST_TX_FIRE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |-> ($past(tx_enable) && $past(ring_split) != '0)); // R4
    AST_TX_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |-> (tx_index == '0 || tx_index == $past(tx_index) + IDX_W'(1))); // R5
    AST_TX_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |-> ({1'b0, tx_index} < $past(ring_split))); // R5
    AST_TXEN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |=> tx_index == '0); // R10
    AST_RXEN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_enable) |=> rx_index == $past(ring_split[IDX_W-1:0])); // R10
    AST_RX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> $stable(rx_index)); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_src) & ~irq_src & ~$past(irq_clr)) == '0); // R11
endmodule

bind desc_ring_ctrl desc_ring_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .split_we   (split_we),
    .ring_split (ring_split),
    .tx_enable  (tx_enable),
    .rx_enable  (rx_enable),
    .tx_fire    (tx_fire),
    .tx_index   (tx_index),
    .rx_index   (rx_index),
    .irq_clr    (irq_clr),
    .irq_src    (irq_src)
);

// File: tb/sim_desc_ring_ctrl.sv
module sim_desc_ring_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_en = 1'b0, host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        split_we = 1'b0;
    logic [7:0]  split_wdata = '0, ring_split;
    logic        tx_enable = 1'b0, rx_enable = 1'b0;
    logic        rx_ev_valid = 1'b0, rx_ev_miss = 1'b0, rx_ready;
    logic [15:0] rx_ev_len = '0, tx_len;
    logic        tx_fire;
    logic [31:0] tx_ptr;
    logic [6:0]  tx_index, rx_index;
    logic [4:0]  irq_clr = '0, irq_src;

    int checks = 0;
    int errors = 0;
    logic [47:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_ring_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .split_we(split_we), .split_wdata(split_wdata), .ring_split(ring_split),
        .tx_enable(tx_enable), .rx_enable(rx_enable), .rx_ev_valid(rx_ev_valid),
        .rx_ev_len(rx_ev_len), .rx_ev_miss(rx_ev_miss), .rx_ready(rx_ready),
        .tx_fire(tx_fire), .tx_len(tx_len), .tx_ptr(tx_ptr), .tx_index(tx_index),
        .rx_index(rx_index), .irq_clr(irq_clr), .irq_src(irq_src)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: every transmit start must match the next expected item
    always @(negedge clk) begin
        if (rst_n && tx_fire) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected start: actual=%h expected=none", {tx_len, tx_ptr});
            end else begin
                logic [47:0] e;
                e = exp_q.pop_front();
                if ({tx_len, tx_ptr} !== e) begin
                    errors++;
                    $display("FAIL R4 start data: actual=%h expected=%h", {tx_len, tx_ptr}, e);
                end
            end
        end
    end

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic hwr(input int idx, input int word, input logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1;
        host_addr = 10'(idx * 8 + word * 4); host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
        settle();
    endtask

    task automatic hrd(input int idx, input int word, output logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = 10'(idx * 8 + word * 4);
        @(negedge clk);
        d = host_rdata;
        host_en = 1'b0;
    endtask

    task automatic split_wr(input logic [7:0] v);
        @(negedge clk);
        split_we = 1'b1; split_wdata = v;
        @(negedge clk);
        split_we = 1'b0;
    endtask

    task automatic rx_ev(input logic [15:0] l, input logic m);
        @(negedge clk);
        rx_ev_valid = 1'b1; rx_ev_len = l; rx_ev_miss = m;
        @(negedge clk);
        rx_ev_valid = 1'b0;
        settle();
    endtask

    task automatic irq_clear();
        @(negedge clk);
        irq_clr = 5'h1F;
        @(negedge clk);
        irq_clr = 5'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 split", 32'(ring_split), 32'd64);
        check("R1 tx idx", 32'(tx_index), 32'd0);
        check("R1 rx idx", 32'(rx_index), 32'd64);
        check("R1 irq", 32'(irq_src), 32'd0);
        hrd(3, 1, d);
        check("R1 word zero", d, 32'h0);

        // R2 split writes
        split_wr(8'd200);
        check("R2 ignored", 32'(ring_split), 32'd64);
        split_wr(8'd128);
        check("R2 ignored 128", 32'(ring_split), 32'd64);
        split_wr(8'd4);
        check("R2 taken", 32'(ring_split), 32'd4);

        // R4 no start while disabled
        hwr(0, 1, 32'hA000_0000);
        hwr(0, 0, {16'd60, 16'hC0FF});
        check("R4 disabled no move", 32'(tx_index), 32'd0);
        hrd(0, 1, d);
        check("R1 pointer word", d, 32'hA000_0000);

        // R10 enable edge triggers a check; R6 status rewrite
        exp_q.push_back({16'd60, 32'hA000_0000});
        @(negedge clk); tx_enable = 1'b1;
        settle();
        hrd(0, 0, d);
        check("R6 tx status", d, {16'd60, 16'h4000});
        check("R6 tx irq", 32'(irq_src[0]), 32'd1);
        check("R5 tx idx step", 32'(tx_index), 32'd1);
        irq_clear();

        // R4 length of 4 is not enough
        hwr(1, 0, {16'd4, 16'h8000});
        check("R4 short len", 32'(tx_index), 32'd1);
        // R5 wrap bit
        exp_q.push_back({16'd5, 32'h0});
        hwr(1, 0, {16'd5, 16'hA000});
        check("R5 wrap bit", 32'(tx_index), 32'd0);
        check("R6 no irq flag", 32'(irq_src[0]), 32'd0);

        // R5 wrap at split boundary 4
        for (int k = 0; k < 4; k++) begin
            hwr(k, 1, 32'h1000_0000 + 32'(k));
            exp_q.push_back({16'd10, 32'h1000_0000 + 32'(k)});
            hwr(k, 0, {16'd10, 16'h8000});
            check("R5 ring step", 32'(tx_index), 32'((k + 1) % 4));
        end
        check("R4 all starts seen", 32'(exp_q.size()), 32'd0);

        // R10 receive reload
        @(negedge clk); rx_enable = 1'b1;
        settle();
        check("R10 rx reload", 32'(rx_index), 32'd4);
        check("R3 rx ready", 32'(rx_ready), 32'd1);

        // R8 accepted with miss
        hwr(4, 0, {16'd0, 16'hC17F});
        rx_ev(16'd100, 1'b1);
        hrd(4, 0, d);
        check("R8 rx status miss", d, {16'd100, 16'h4080});
        check("R8 rx irq", 32'(irq_src[2]), 32'd1);
        check("R9 rx step", 32'(rx_index), 32'd5);
        irq_clear();
        hwr(5, 0, {16'd0, 16'hA080});
        rx_ev(16'd64, 1'b0);
        hrd(5, 0, d);
        check("R8 rx status hit", d, {16'd64, 16'h2000});
        check("R8 no irq flag", 32'(irq_src[2]), 32'd0);
        check("R9 wrap bit", 32'(rx_index), 32'd4);

        // R7 busy drop
        rx_ev(16'd77, 1'b0);
        hrd(4, 0, d);
        check("R7 desc intact", d, {16'd100, 16'h4080});
        check("R7 busy bit", 32'(irq_src[4]), 32'd1);
        check("R7 idx held", 32'(rx_index), 32'd4);
        irq_clear();
        check("R11 cleared", 32'(irq_src), 32'd0);

        // R3 disabled receive ignored
        @(negedge clk); rx_enable = 1'b0;
        hwr(4, 0, {16'd0, 16'h8000});
        check("R3 not ready", 32'(rx_ready), 32'd0);
        rx_ev(16'd50, 1'b1);
        hrd(4, 0, d);
        check("R3 desc untouched", d, {16'd0, 16'h8000});
        check("R3 idx untouched", 32'(rx_index), 32'd4);
        check("R3 no irq", 32'(irq_src), 32'd0);

        // R9 top index wraps back to split
        split_wr(8'd126);
        @(negedge clk); rx_enable = 1'b1;
        settle();
        check("R10 rx reload 126", 32'(rx_index), 32'd126);
        hwr(126, 0, {16'd0, 16'h8000});
        hwr(127, 0, {16'd0, 16'h8000});
        rx_ev(16'd20, 1'b0);
        check("R9 to 127", 32'(rx_index), 32'd127);
        rx_ev(16'd21, 1'b0);
        check("R9 127 wraps", 32'(rx_index), 32'd126);
        hrd(127, 0, d);
        check("R8 desc 127", d, {16'd21, 16'h0000});

        // R12 collision: host and ring write the same word together
        hwr(126, 0, {16'd0, 16'hC000});
        @(negedge clk);
        rx_ev_valid = 1'b1; rx_ev_len = 16'd33; rx_ev_miss = 1'b0;
        host_en = 1'b1; host_we = 1'b1; host_addr = 10'(126 * 8); host_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        rx_ev_valid = 1'b0; host_en = 1'b0; host_we = 1'b0;
        settle();
        hrd(126, 0, d);
        check("R12 ring wins", d, {16'd33, 16'h4000});
        check("R12 idx", 32'(rx_index), 32'd127);

        // R11 set wins over clear in the same cycle
        hwr(127, 0, {16'd0, 16'hC000});
        @(negedge clk);
        rx_ev_valid = 1'b1; rx_ev_len = 16'd9; irq_clr = 5'h1F;
        @(negedge clk);
        rx_ev_valid = 1'b0; irq_clr = 5'h00;
        check("R11 set beats clear", 32'(irq_src), 32'h4);
        settle();
        check("R11 sticky", 32'(irq_src), 32'h4);
        check("R4 no stray starts", 32'(exp_q.size()), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule